// File: doc/BRIEF.md
# Packed Rounding Add-Narrow Unit

This unit is a packed SIMD datapath stage. It takes two operand vectors of a fixed, parameterised width and cuts them into equal unsigned lanes whose width is chosen by a 2-bit size code. It adds each pair of lanes at full precision and adds a rounding constant of half a narrow unit. It then keeps only the upper half of each lane's sum. That narrowed value goes into the lower (even-indexed) half of the lane's position in the result, and the upper (odd-indexed) half is cleared.

One register stage sits behind the arithmetic, so every accepted operation appears exactly one cycle later whatever the data. A request with the reserved size code gives a one-cycle illegal-size pulse in place of a result, and it leaves the result register untouched.

Top module: `rnd_addnarrow_top`

## Requirements
- R1: Size code 2'b01 splits the operands into 16-bit lanes. Source lane e narrows to 8 bits at result bits [16e+7:16e].
- R2: Size code 2'b10 splits the operands into 32-bit lanes. Source lane e narrows to 16 bits at result bits [32e+15:32e].
- R3: Size code 2'b11 splits the operands into 64-bit lanes. Source lane e narrows to 32 bits at result bits [64e+31:64e].
- R4: For a lane of W bits with H = W/2, the narrowed value is bits [2H-1:H] of the unsigned sum a + b + (1 << (H-1)). That sum is formed with at least W+1 bits.
- R5: Any carry above bit W-1 of that sum is dropped. For example, all-ones plus all-ones in any lane narrows to zero.
- R6: Whenever out_valid is high, the upper half of every source-lane position in out_result is zero.
- R7: With in_valid high and size code 2'b00, out_illegal is high and out_valid is low in the next cycle, and out_result keeps its previous value.
- R8: out_valid is high in the cycle after an accepted request with a legal size, and only then. With in_valid low, neither output flag rises and out_result is held. The latency is always one cycle.
- R9: While rst_n is low, out_valid, out_illegal and out_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| in_size | input | 2 | Lane size code (01/10/11 = 16/32/64-bit lanes, 00 reserved) |
| in_a | input | VEC_W | First operand vector |
| in_b | input | VEC_W | Second operand vector |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| out_illegal | output | 1 | Reserved size code seen, one cycle after the request |
| out_result | output | VEC_W | Narrowed, interleaved result |

## Verification
There is no state apart from the output register. A wrong lane split, a wrong rounding offset or a kept carry therefore shows up as a wrong out_result in the very cycle after the request. A broken load enable shows the other way: a result that changes after an idle or illegal cycle, again one cycle later. Random operands at all four size codes are compared with a bench model. Directed all-ones, all-zeros and rounding-threshold patterns cover the carry and tie cases.

// File: rtl/rnd_addnarrow_pkg.sv
package rnd_addnarrow_pkg;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_16   = 2'b01,
    SZ_32   = 2'b10,
    SZ_64   = 2'b11
  } lane_size_e;

  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned MIN_LANE_W = 16;

  // source lane width for a legal size code
  function automatic int unsigned lane_width(input lane_size_e sz);
    return 8 << sz;
  endfunction

endpackage

// File: rtl/rna_lane.sv
module rna_lane #(
  parameter int unsigned SRC_W = 16
) (
  input  logic [SRC_W-1:0] lane_a,
  input  logic [SRC_W-1:0] lane_b,
  output logic [SRC_W-1:0] lane_out
);
  localparam int unsigned HALF_W = SRC_W / 2;
  localparam logic [SRC_W:0] RND = (SRC_W+1)'(1) << (HALF_W - 1);

  logic [SRC_W:0] full_sum;

  always_comb begin
    full_sum = {1'b0, lane_a} + {1'b0, lane_b} + RND;
    // bit SRC_W (carry) dropped; low narrow slot holds upper half
    lane_out = {{HALF_W{1'b0}}, full_sum[SRC_W-1:HALF_W]};
  end

endmodule

// File: rtl/rna_bank.sv
module rna_bank #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned SRC_W = 16
) (
  input  logic [VEC_W-1:0] vec_a,
  input  logic [VEC_W-1:0] vec_b,
  output logic [VEC_W-1:0] vec_out
);
  localparam int unsigned LANES = VEC_W / SRC_W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    rna_lane #(.SRC_W(SRC_W)) lane_i (
      .lane_a  (vec_a[e*SRC_W +: SRC_W]),
      .lane_b  (vec_b[e*SRC_W +: SRC_W]),
      .lane_out(vec_out[e*SRC_W +: SRC_W])
    );
  end

endmodule

// File: rtl/rna_select.sv
module rna_select
  import rnd_addnarrow_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  lane_size_e       sel_size,
  input  logic [VEC_W-1:0] res_16,
  input  logic [VEC_W-1:0] res_32,
  input  logic [VEC_W-1:0] res_64,
  output logic             sel_legal,
  output logic [VEC_W-1:0] sel_result
);

  always_comb begin
    sel_legal  = 1'b1;
    sel_result = '0;
    unique case (sel_size)
      SZ_16:   sel_result = res_16;
      SZ_32:   sel_result = res_32;
      SZ_64:   sel_result = res_64;
      default: sel_legal  = 1'b0;
    endcase
  end

endmodule

// File: rtl/rna_outreg.sv
module rna_outreg
  import rnd_addnarrow_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_legal,
  input  lane_size_e       req_size,
  input  logic [VEC_W-1:0] req_result,
  output logic             q_valid,
  output logic             q_illegal,
  output logic [VEC_W-1:0] q_result
);
  localparam int unsigned SLOTS8 = VEC_W / 8;

  logic             load;
  logic             valid_d, illegal_d;
  logic [VEC_W-1:0] result_d;
  lane_size_e       size_q, size_d;

  always_comb begin
    load      = req_valid & req_legal;
    valid_d   = load;
    illegal_d = req_valid & ~req_legal;
    result_d  = q_result;
    size_d    = size_q;
    if (load) begin
      result_d = req_result;
      size_d   = req_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_illegal <= 1'b0;
    end else begin
      q_valid   <= valid_d;
      q_illegal <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_result <= '0;
      size_q   <= SZ_RSVD;
    end else if (load) begin
      q_result <= result_d;
      size_q   <= size_d;
    end
  end

  // mask of upper-half bits of every source lane for the held size
  function automatic logic [VEC_W-1:0] upper_mask(input lane_size_e sz);
    logic [VEC_W-1:0] m;
    int unsigned w;
    m = '0;
    w = (sz == SZ_RSVD) ? MIN_LANE_W : lane_width(sz);
    for (int i = 0; i < VEC_W; i++)
      if ((i % w) >= (w / 2)) m[i] = 1'b1;
    return m;
  endfunction

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_valid && q_illegal));

  p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SZ_RSVD) |=> q_valid);

  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_size != SZ_RSVD) |=> !q_valid);

  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SZ_RSVD) |=> (q_illegal && !q_valid));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_size != SZ_RSVD) |=> $stable(q_result));

  p_odd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> ((q_result & upper_mask(size_q)) == '0));

  p_mask_sane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(upper_mask(SZ_16)) == SLOTS8 * 4);

endmodule

// File: rtl/rnd_addnarrow_top.sv
module rnd_addnarrow_top
  import rnd_addnarrow_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_size,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [VEC_W-1:0] out_result
);

  if ((VEC_W % 64) != 0 || VEC_W == 0) begin : g_bad_width
    $error("VEC_W must be a non-zero multiple of 64");
  end

  logic [VEC_W-1:0] bank_res [NUM_SIZES];
  logic [VEC_W-1:0] sel_result;
  logic             sel_legal;
  lane_size_e       size_e;

  assign size_e = lane_size_e'(in_size);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_bank
    rna_bank #(.VEC_W(VEC_W), .SRC_W(MIN_LANE_W << k)) bank_i (
      .vec_a  (in_a),
      .vec_b  (in_b),
      .vec_out(bank_res[k])
    );
  end

  rna_select #(.VEC_W(VEC_W)) select_i (
    .sel_size  (size_e),
    .res_16    (bank_res[0]),
    .res_32    (bank_res[1]),
    .res_64    (bank_res[2]),
    .sel_legal (sel_legal),
    .sel_result(sel_result)
  );

  rna_outreg #(.VEC_W(VEC_W)) outreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (in_valid),
    .req_legal (sel_legal),
    .req_size  (size_e),
    .req_result(sel_result),
    .q_valid   (out_valid),
    .q_illegal (out_illegal),
    .q_result  (out_result)
  );

endmodule

// File: tb/rnd_addnarrow_top_tb_top.sv
module rnd_addnarrow_top_tb_top;
  localparam int unsigned VW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_size;
  logic [VW-1:0] in_a, in_b;
  logic          out_valid, out_illegal;
  logic [VW-1:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [VW-1:0] exp_res;

  always #2.5 clk = ~clk;

  rnd_addnarrow_top #(.VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_size(in_size),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_result(out_result)
  );

  function automatic logic [VW-1:0] model(logic [1:0] sz, logic [VW-1:0] a, logic [VW-1:0] b);
    logic [VW-1:0] r = '0;
    int w = 8 << sz;
    int h = w / 2;
    for (int e = 0; e < VW / w; e++) begin
      logic [64:0] ea = '0, eb = '0, s;
      for (int i = 0; i < w; i++) begin
        ea[i] = a[e*w+i];
        eb[i] = b[e*w+i];
      end
      s = ea + eb + (65'd1 << (h - 1));
      for (int i = 0; i < h; i++) r[e*w+i] = s[h+i];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [VW-1:0] got, logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic string tag(logic [1:0] sz);
    case (sz)
      2'b01: return "R1/R4";
      2'b10: return "R2/R4";
      2'b11: return "R3/R4";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(logic v, logic [1:0] sz, logic [VW-1:0] a, logic [VW-1:0] b, string req);
    logic ev, ei;
    @(negedge clk);
    in_valid = v; in_size = sz; in_a = a; in_b = b;
    ev = v && (sz != 2'b00);
    ei = v && (sz == 2'b00);
    if (ev) exp_res = model(sz, a, b);
    @(posedge clk); #1;
    chk({req, " R8 valid"}, VW'(out_valid), VW'(ev));
    chk({req, " R7 illegal"}, VW'(out_illegal), VW'(ei));
    chk({req, " result"}, out_result, exp_res);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] ones = '1;
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; in_valid = 0; in_size = 0; in_a = '0; in_b = '0;
    exp_res = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", VW'(out_valid), '0);
    chk("R9 illegal", VW'(out_illegal), '0);
    chk("R9 result", out_result, '0);
    rst_n = 1'b1;

    // directed corners
    apply(1, 2'b01, ones, ones, "R5 carry drop 16");
    chk("R5 all-ones 16", out_result, '0);
    apply(1, 2'b10, ones, ones, "R5 carry drop 32");
    apply(1, 2'b11, ones, ones, "R5 carry drop 64");
    apply(1, 2'b01, {8{16'h007F}}, {8{16'h0000}}, "R4 below threshold");
    apply(1, 2'b01, {8{16'h0080}}, {8{16'h0000}}, "R4 at threshold");
    chk("R4 round up 16", out_result, {8{16'h0001}});
    apply(1, 2'b10, {4{32'h0000_7FFF}}, {4{32'h0000_0001}}, "R2 threshold");
    chk("R2 round 32", out_result, {4{32'h0000_0001}});
    apply(1, 2'b11, {2{64'h1234_5678_9ABC_DEF0}}, {2{64'h0FED_CBA9_8765_4321}}, "R3 pattern");
    apply(0, 2'b01, ones, '0, "R8 idle hold");
    apply(1, 2'b00, ones, ones, "R7 reserved hold");
    apply(1, 2'b01, '0, '0, "R1 zeros");
    apply(1, 2'b00, {VW/32{32'hDEAD_BEEF}}, '0, "R7 reserved after zero");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic v = ($urandom_range(0, 9) != 0);
      logic [VW-1:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [VW-1:0] b = {$urandom, $urandom, $urandom, $urandom};
      if (n % 7 == 0) a = ~b;
      apply(v, sz, a, b, {"rand ", tag(sz), " R6"});
    end

    // R9: reset after activity clears result
    apply(1, 2'b11, ones, {VW{1'b0}}, "R3 pre-reset");
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk("R9 async clear valid", VW'(out_valid), '0);
    chk("R9 async clear result", out_result, '0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_res = '0;
    apply(0, 2'b10, ones, ones, "R8 idle after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule